// File: doc/BRIEF.md
# Packet Parser and Ring Router

This block sits on a node of a ring of devices and takes in a byte-wide stream of packets, arriving either from the host link or from the upstream ring link. It hunts for the start marker, collects the nine header bytes into a small store and, once the header is complete, makes one routing decision. A packet whose device identifier equals this node's identifier has its header fields presented on a local consumer interface, and its payload is streamed to that consumer. Any other packet is sent unchanged on the downstream ring port, header first, so the next node can parse it.

Header layout, one byte per position and multi-byte fields most significant byte first: position 0 start marker (8'hA5), 1 device identifier, 2..3 function identifier, 4 command code, 5..6 payload length in bytes, 7..8 memory address. The payload follows directly. A length above the maximum payload (1024 bytes) is treated as malformed. Such a packet is consumed from the input and discarded, and a sticky flag is set. Bytes seen between packets that are not the start marker are thrown away and counted.

All three byte streams use a valid/ready handshake. The block holds no payload storage, so in the payload phase the input ready follows the ready of whichever output was chosen.

Top module: `pkt_route_node`

## Requirements
- R1: While idle, an accepted byte other than 8'hA5 is discarded without output, and `sync_err_cnt` increases by one (saturating at all ones). An accepted 8'hA5 begins a header.
- R2: For a packet whose device identifier (position 1) equals `node_id`, `loc_hdr_valid` pulses for exactly one cycle after the last header byte is accepted. In that cycle the field outputs hold function ID {pos2,pos3}, command pos4, length {pos5,pos6} and address {pos7,pos8}.
- R3: The payload bytes of a matching packet appear on `loc_data` in arrival order, with `loc_last` set on the final byte only.
- R4: For a non-matching packet, all nine header bytes and then every payload byte appear unchanged and in order on `fwd_data`, with `fwd_last` set on the final byte only. A held forward byte stays stable until it is accepted.
- R5: A packet of length 0 produces only the header pulse when local. When forwarded it produces exactly the nine header bytes, with `fwd_last` on the address low byte.
- R6: A length above 1024 sets `len_err`, which then stays set until reset. That many payload bytes are accepted and dropped, nothing appears on either output, and parsing resumes after them.
- R7: While header bytes are being sent forward, `in_ready` is low. In the payload phase, `in_ready` equals `loc_ready` for local packets and `fwd_ready` for forwarded packets.
- R8: After reset, `in_ready` is high, all output valids and `len_err` are low, and `sync_err_cnt` is zero.
- R9: A length of exactly 1024 is legal, and all 1024 payload bytes are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| node_id | input | 8 | This node's device identifier (static) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| loc_hdr_valid | output | 1 | One-cycle pulse: header fields of a local packet are valid |
| loc_func_id | output | 16 | Function identifier of the current local packet |
| loc_cmd | output | 8 | Command code of the current local packet |
| loc_len | output | 16 | Payload length of the current local packet |
| loc_addr | output | 16 | Start address of the current local packet |
| loc_valid | output | 1 | Local payload byte valid |
| loc_data | output | 8 | Local payload byte |
| loc_last | output | 1 | Final payload byte of the local packet |
| loc_ready | input | 1 | Local consumer ready |
| fwd_valid | output | 1 | Forward byte valid |
| fwd_data | output | 8 | Forward byte (header or payload) |
| fwd_last | output | 1 | Final byte of the forwarded packet |
| fwd_ready | input | 1 | Downstream ring port ready |
| len_err | output | 1 | Sticky flag: a length above the maximum was seen |
| sync_err_cnt | output | 8 | Count of discarded bytes seen between packets |

## Verification
The assertions take for granted that a source holding `in_valid` keeps it high and keeps `in_data` unchanged until the byte is taken, and that `node_id` does not change while traffic flows. The forward-stability check depends on this, because payload bytes pass straight from input to forward port. The stimulus keeps to these rules: a byte, once offered, is held until a handshake, while gaps between bytes and both output readies are random. The bench then interleaves stray bytes, local and forwarded packets, zero-length packets, a 1024-byte payload and an oversize packet followed by a good one.

// File: rtl/pkt_route_pkg.sv
package pkt_route_pkg;
  localparam int HDR_BYTES = 9;
  localparam int IDX_W     = 4;

  // header byte positions; the routing and field logic decode these
  localparam int POS_DID     = 1;
  localparam int POS_FID_HI  = 2;
  localparam int POS_FID_LO  = 3;
  localparam int POS_CMD     = 4;
  localparam int POS_LEN_HI  = 5;
  localparam int POS_LEN_LO  = 6;
  localparam int POS_ADDR_HI = 7;
  localparam int POS_ADDR_LO = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_REPLAY,
    ST_FWD,
    ST_LOC,
    ST_DROP
  } rt_state_e;
endpackage

// File: rtl/pkt_hdr_store.sv
module pkt_hdr_store
  import pkt_route_pkg::*;
#(
  parameter int NBYTES = HDR_BYTES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [7:0]                   wr_data,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [NBYTES-1:0][7:0]       hdr_q,
  output logic [7:0]                   rd_data
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic en;
    assign en = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hdr_q[g] <= '0;
      else if (en) hdr_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = hdr_q[i];
    end
  end

endmodule

// File: rtl/pkt_pay_counter.sv
module pkt_pay_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         cnt_one,
  output logic         cnt_zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_one  = (cnt_q == W'(1));
  assign cnt_zero = (cnt_q == '0);

  // R6
  dec_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !cnt_zero);

endmodule

// File: rtl/pkt_route_ctrl.sv
module pkt_route_ctrl
  import pkt_route_pkg::*;
#(
  parameter int         LEN_W   = 16,
  parameter int         MAX_PAY = 1024,
  parameter int         ERR_W   = 8,
  parameter logic [7:0] SOP_VAL = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       node_id,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             loc_ready,
  input  logic             fwd_ready,
  input  logic [7:0]       did,
  input  logic [LEN_W-1:0] pay_len,
  input  logic             cnt_one,
  output logic             in_ready,
  output logic             hdr_wr,
  output logic [IDX_W-1:0] hdr_idx,
  output logic             cnt_load,
  output logic             cnt_dec,
  output logic             loc_valid,
  output logic             loc_last,
  output logic             fwd_valid,
  output logic             fwd_from_hdr,
  output logic             fwd_last,
  output logic             hdr_pulse,
  output logic             len_err,
  output logic [ERR_W-1:0] err_cnt
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);
  localparam logic [LEN_W-1:0] MAX_LEN  = LEN_W'(MAX_PAY);

  rt_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pulse_q, pulse_d;
  logic             lerr_q, lerr_d;
  logic [ERR_W-1:0] err_q, err_d;

  logic acc, hdr_done, over, match, empty_pay, is_sop;

  assign acc       = in_valid && in_ready;
  assign over      = pay_len > MAX_LEN;
  assign match     = (did == node_id);
  assign empty_pay = (pay_len == '0);
  assign is_sop    = (in_data == SOP_VAL);
  assign hdr_done  = (state_q == ST_HDR) && acc && (idx_q == LAST_IDX);

  always_comb begin
    unique case (state_q)
      ST_REPLAY: in_ready = 1'b0;
      ST_FWD:    in_ready = fwd_ready;
      ST_LOC:    in_ready = loc_ready;
      default:   in_ready = 1'b1;
    endcase
  end

  assign loc_valid    = (state_q == ST_LOC) && in_valid;
  assign loc_last     = (state_q == ST_LOC) && cnt_one;
  assign fwd_from_hdr = (state_q == ST_REPLAY);
  assign fwd_valid    = fwd_from_hdr || ((state_q == ST_FWD) && in_valid);
  assign fwd_last     = fwd_from_hdr ? ((idx_q == LAST_IDX) && empty_pay)
                                     : ((state_q == ST_FWD) && cnt_one);

  assign hdr_wr   = acc && (((state_q == ST_IDLE) && is_sop) || (state_q == ST_HDR));
  assign hdr_idx  = (state_q == ST_IDLE) ? '0 : idx_q;
  assign cnt_load = hdr_done;
  assign cnt_dec  = acc && ((state_q == ST_FWD) || (state_q == ST_LOC) || (state_q == ST_DROP));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    pulse_d = hdr_done && !over && match;
    lerr_d  = lerr_q || (hdr_done && over);
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (acc && is_sop) begin
          state_d = ST_HDR;
          idx_d   = IDX_W'(1);
        end else if (acc && (err_q != '1)) begin
          err_d = err_q + ERR_W'(1);
        end
      end
      ST_HDR: begin
        if (acc) begin
          if (idx_q == LAST_IDX) begin
            idx_d = '0;
            if (over)           state_d = ST_DROP;
            else if (!match)    state_d = ST_REPLAY;
            else if (empty_pay) state_d = ST_IDLE;
            else                state_d = ST_LOC;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      ST_REPLAY: begin
        if (fwd_ready) begin
          if (idx_q == LAST_IDX) begin
            idx_d   = '0;
            state_d = empty_pay ? ST_IDLE : ST_FWD;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      default: begin
        if (acc && cnt_one) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pulse_q <= 1'b0;
      lerr_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pulse_q <= pulse_d;
      lerr_q  <= lerr_d;
      err_q   <= err_d;
    end
  end

  assign hdr_pulse = pulse_q;
  assign len_err   = lerr_q;
  assign err_cnt   = err_q;

  // R2
  hdr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_pulse |=> !hdr_pulse);

  // R6
  len_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);

  // R1
  err_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != $past(err_cnt)) |-> (err_cnt == $past(err_cnt) + ERR_W'(1)));

endmodule

// File: rtl/pkt_route_node.sv
module pkt_route_node
  import pkt_route_pkg::*;
#(
  parameter int         LEN_W   = 16,
  parameter int         MAX_PAY = 1024,
  parameter int         ERR_W   = 8,
  parameter logic [7:0] SOP_VAL = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       node_id,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             loc_hdr_valid,
  output logic [15:0]      loc_func_id,
  output logic [7:0]       loc_cmd,
  output logic [LEN_W-1:0] loc_len,
  output logic [15:0]      loc_addr,
  output logic             loc_valid,
  output logic [7:0]       loc_data,
  output logic             loc_last,
  input  logic             loc_ready,
  output logic             fwd_valid,
  output logic [7:0]       fwd_data,
  output logic             fwd_last,
  input  logic             fwd_ready,
  output logic             len_err,
  output logic [ERR_W-1:0] sync_err_cnt
);

  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  logic                      hdr_wr, cnt_load, cnt_dec, cnt_one, cnt_zero, fwd_from_hdr;
  logic [IDX_W-1:0]          hdr_idx;
  logic [HDR_BYTES-1:0][7:0] hdr_q;
  logic [7:0]                hdr_rd;
  logic [LEN_W-1:0]          pay_len;

  pkt_hdr_store #(.NBYTES(HDR_BYTES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (hdr_wr),
    .wr_idx  (hdr_idx),
    .wr_data (in_data),
    .rd_idx  (hdr_idx),
    .hdr_q   (hdr_q),
    .rd_data (hdr_rd)
  );

  assign pay_len = LEN_W'({hdr_q[POS_LEN_HI], hdr_q[POS_LEN_LO]});

  pkt_pay_counter #(.W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (cnt_load),
    .load_val (pay_len),
    .dec      (cnt_dec),
    .cnt_one  (cnt_one),
    .cnt_zero (cnt_zero)
  );

  pkt_route_ctrl #(
    .LEN_W   (LEN_W),
    .MAX_PAY (MAX_PAY),
    .ERR_W   (ERR_W),
    .SOP_VAL (SOP_VAL)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .node_id      (node_id),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .loc_ready    (loc_ready),
    .fwd_ready    (fwd_ready),
    .did          (hdr_q[POS_DID]),
    .pay_len      (pay_len),
    .cnt_one      (cnt_one),
    .in_ready     (in_ready),
    .hdr_wr       (hdr_wr),
    .hdr_idx      (hdr_idx),
    .cnt_load     (cnt_load),
    .cnt_dec      (cnt_dec),
    .loc_valid    (loc_valid),
    .loc_last     (loc_last),
    .fwd_valid    (fwd_valid),
    .fwd_from_hdr (fwd_from_hdr),
    .fwd_last     (fwd_last),
    .hdr_pulse    (loc_hdr_valid),
    .len_err      (len_err),
    .err_cnt      (sync_err_cnt)
  );

  assign loc_func_id = {hdr_q[POS_FID_HI], hdr_q[POS_FID_LO]};
  assign loc_cmd     = hdr_q[POS_CMD];
  assign loc_len     = pay_len;
  assign loc_addr    = {hdr_q[POS_ADDR_HI], hdr_q[POS_ADDR_LO]};
  assign loc_data    = in_data;
  assign fwd_data    = fwd_from_hdr ? hdr_rd : in_data;

  // R4
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_data)));

  // R7
  replay_stall_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fwd_valid && !in_valid) |-> !in_ready);

endmodule

// File: tb/tb_pkt_route_node.sv
`timescale 1ns/1ps
module tb_pkt_route_node;
  localparam logic [7:0] NODE = 8'h3C;

  logic        clk, rst_n;
  logic        in_valid, in_ready, loc_ready, fwd_ready;
  logic [7:0]  in_data;
  logic        loc_hdr_valid, loc_valid, loc_last, fwd_valid, fwd_last, len_err;
  logic [15:0] loc_func_id, loc_len, loc_addr;
  logic [7:0]  loc_cmd, loc_data, fwd_data, sync_err_cnt;

  pkt_route_node dut (
    .clk(clk), .rst_n(rst_n), .node_id(NODE),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .loc_hdr_valid(loc_hdr_valid), .loc_func_id(loc_func_id), .loc_cmd(loc_cmd),
    .loc_len(loc_len), .loc_addr(loc_addr),
    .loc_valid(loc_valid), .loc_data(loc_data), .loc_last(loc_last), .loc_ready(loc_ready),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_last(fwd_last), .fwd_ready(fwd_ready),
    .len_err(len_err), .sync_err_cnt(sync_err_cnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0]  q_in[$];
  logic [9:0]  q_fwd[$];   // {is_header, last, data}
  logic [8:0]  q_loc[$];   // {last, data}
  logic [55:0] q_hdr[$];   // {func, cmd, len, addr}
  int exp_err_cnt = 0;
  bit exp_len_err = 0;
  int exp_loc_bytes = 0, got_loc_bytes = 0;
  int exp_fwd_pkts = 0, got_fwd_pkts = 0;
  int exp_hdr_n = 0, got_hdr_n = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_junk(input logic [7:0] b);
    q_in.push_back(b);
    exp_err_cnt++;
  endtask

  task automatic add_pkt(input logic [7:0] did, input logic [15:0] fid, input logic [7:0] cmd,
                         input logic [15:0] len, input logic [15:0] addr, input int seed);
    logic [7:0] h[9];
    h = '{8'hA5, did, fid[15:8], fid[7:0], cmd, len[15:8], len[7:0], addr[15:8], addr[7:0]};
    for (int i = 0; i < 9; i++) q_in.push_back(h[i]);
    for (int i = 0; i < int'(len); i++) q_in.push_back(8'((seed + i * 13) & 255));
    if (len > 16'd1024) begin
      exp_len_err = 1;
    end else if (did == NODE) begin
      q_hdr.push_back({fid, cmd, len, addr});
      exp_hdr_n++;
      for (int i = 0; i < int'(len); i++)
        q_loc.push_back({(i == int'(len) - 1), 8'((seed + i * 13) & 255)});
      exp_loc_bytes += int'(len);
    end else begin
      for (int i = 0; i < 9; i++)
        q_fwd.push_back({1'b1, (i == 8) && (len == 0), h[i]});
      for (int i = 0; i < int'(len); i++)
        q_fwd.push_back({1'b0, (i == int'(len) - 1), 8'((seed + i * 13) & 255)});
      exp_fwd_pkts++;
    end
  endtask

  initial begin
    bit vld = 0;
    int cyc = 0;
    int idle_after = 0;
    in_valid = 0; in_data = 0; loc_ready = 0; fwd_ready = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    // R8: reset state
    chk("R8", "in_ready", in_ready, 1);
    chk("R8", "loc_valid", loc_valid, 0);
    chk("R8", "fwd_valid", fwd_valid, 0);
    chk("R8", "loc_hdr_valid", loc_hdr_valid, 0);
    chk("R8", "len_err", len_err, 0);
    chk("R8", "sync_err_cnt", sync_err_cnt, 0);

    // R1 stray bytes, then a mix of packets
    add_junk(8'h00); add_junk(8'h5A); add_junk(8'hFF);
    add_pkt(NODE,  16'h1234, 8'h01, 16'd3,    16'hABCD, 7);    // R3 local
    add_pkt(8'h11, 16'h0F0E, 8'h02, 16'd5,    16'h0102, 40);   // R4 forward
    add_pkt(NODE,  16'h2222, 8'h03, 16'd0,    16'h0033, 0);    // R5 local empty
    add_pkt(8'h77, 16'h4444, 8'h02, 16'd0,    16'h5555, 0);    // R5 forward empty
    add_junk(8'hA4);
    add_pkt(NODE,  16'hBEEF, 8'h02, 16'd1024, 16'h0400, 3);    // R9 maximum payload
    add_pkt(NODE,  16'h0001, 8'h01, 16'd1100, 16'h0000, 9);    // R6 oversize, dropped
    add_pkt(NODE,  16'h9999, 8'h01, 16'd2,    16'h0010, 100);  // recovery after drop
    add_pkt(8'hC3, 16'h7777, 8'h05, 16'd1,    16'hFFFF, 200);  // R4 one-byte forward

    forever begin
      @(negedge clk);
      cyc++;
      if (!vld && q_in.size() > 0 && $urandom_range(3, 0) != 0) vld = 1;
      in_valid  = vld;
      in_data   = vld ? q_in[0] : 8'h00;
      loc_ready = ($urandom_range(99, 0) < 75);
      fwd_ready = ($urandom_range(99, 0) < 75);
      #1;
      // R2 header pulse and fields
      if (loc_hdr_valid) begin
        got_hdr_n++;
        if (q_hdr.size() == 0) chk("R2", "unexpected header pulse", 1, 0);
        else chk("R2", "header fields", {loc_func_id, loc_cmd, loc_len, loc_addr}, q_hdr.pop_front());
      end
      // R3 / R7 local stream
      if (loc_valid) begin
        chk("R7", "in_ready follows loc_ready", in_ready, loc_ready);
        if (loc_ready) begin
          got_loc_bytes++;
          if (q_loc.size() == 0) chk("R3", "unexpected local byte", 1, 0);
          else chk("R3", "local {last,data}", {loc_last, loc_data}, q_loc.pop_front());
        end
      end
      // R4 / R7 forward stream
      if (fwd_valid) begin
        if (q_fwd.size() == 0) begin
          chk("R4", "unexpected forward byte", 1, 0);
        end else begin
          if (q_fwd[0][9]) chk("R7", "in_ready low during header send", in_ready, 0);
          else             chk("R7", "in_ready follows fwd_ready", in_ready, fwd_ready);
          if (fwd_ready) begin
            logic [9:0] e;
            e = q_fwd.pop_front();
            chk("R4", "forward {last,data}", {fwd_last, fwd_data}, e[8:0]);
            if (fwd_last) got_fwd_pkts++;
          end
        end
      end
      if (vld && in_ready) begin
        void'(q_in.pop_front());
        vld = 0;
      end
      if (q_in.size() == 0 && !vld && q_fwd.size() == 0 && q_loc.size() == 0) idle_after++;
      if (idle_after > 10) break;
      if (cyc > 150000) begin
        chk("WATCHDOG", "run did not finish", 1, 0);
        break;
      end
    end
    in_valid = 0;

    chk("R1", "sync_err_cnt", sync_err_cnt, exp_err_cnt);
    chk("R6", "len_err sticky", len_err, exp_len_err);
    chk("R9", "local bytes delivered incl. 1024-byte payload", got_loc_bytes, exp_loc_bytes);
    chk("R5", "header pulses", got_hdr_n, exp_hdr_n);
    chk("R5", "forwarded packets", got_fwd_pkts, exp_fwd_pkts);
    chk("R6", "no leftover expected local bytes", q_loc.size(), 0);
    chk("R4", "no leftover expected forward bytes", q_fwd.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule